// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every received frame, whether the frame is kept. The frame parser hands it the 48-bit destination address with a one-cycle strobe. One cycle later the block returns a keep/drop verdict, a reason code and, when an exact entry matched, the index of that entry. The parser holds byte 0 of the address (the first byte on the wire) in bits 7:0 and byte 5 in bits 47:40.

Software programs the filter through a simple write port. The port loads a bank of exact-match entries, the words of a 64-bin multicast hash table, a mode register and the count of entries reserved for unicast stations. Exact entries at or above the unicast count still match, but they are reported as multicast matches. The hash bin of an address is a 6-bit XOR fold of all 48 address bits.

The control is a two-state machine. ST_IDLE means no verdict is presented. ST_RESULT means a verdict is on the outputs. The transition ST_IDLE to ST_RESULT and the self-loop on ST_RESULT are both taken when the strobe is high. The transition ST_RESULT to ST_IDLE and the self-loop on ST_IDLE are taken when the strobe is low.

Top module: `rxaf_top`

## Requirements
- R1: After reset no verdict is presented, every exact entry is disabled, both hash words are zero, both modes are off and the unicast count is 1.
- R2: Write addresses with default parameters are as follows. Address 2i is the low word of entry i, holding address bits 31:0 (byte 0 in bits 7:0). Address 2i+1 is the high word of entry i, with address bits 47:32 in bits 15:0 and the entry enable in bit 16. Address 16 is the hash word for bins 0-31 and address 17 is the hash word for bins 32-63, where bin b is bit b mod 32. Address 18 is the mode register, with promiscuous in bit 0 and accept-all-multicast in bit 1. Address 19 is the unicast count.
- R3: A write of 0 to 8 to the unicast count takes effect. A write of a larger value is ignored and leaves the count unchanged.
- R4: An address equal to an enabled entry is accepted and reports the lowest matching index. The reason code is 1 (unicast exact) when that index is below the unicast count, and 2 (multicast exact) otherwise.
- R5: The hash bin is formed as follows. Bit j of the address, taken byte 0 to 5 and LSB first within each byte, is XORed into bin bit j mod 6. A multicast address (bit 0 set) with no exact match is accepted with reason 3 when its bin bit is 1.
- R6: A unicast address never passes through the hash table, even if its bin bit is 1.
- R7: When accept-all-multicast is set, every multicast address is accepted with reason 3. The stored hash words are left unchanged and apply again once the mode is cleared.
- R8: The all-ones address is accepted with reason 4 whatever the hash words hold.
- R9: When promiscuous mode is set, every address is accepted. The reason is 5 when no exact, broadcast or hash rule applies. Otherwise the reason of that rule is kept.
- R10: The verdict appears exactly one cycle after each strobe, including for back-to-back strobes. Without a strobe, valid, accept, reason and index are all 0.
- R11: A disabled entry never matches. Its address then falls through to the next matching entry or to the other rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Frame is kept |
| dec_reason | output | 3 | 0 drop, 1 unicast exact, 2 multicast exact, 3 hash, 4 broadcast, 5 promiscuous |
| dec_idx | output | 3 | Matching exact entry, 0 when none |

## Verification
A wrong stored entry, hash word or mode bit stays hidden until an address that depends on it is looked up. When that happens, it shows in the very next cycle as a wrong accept bit, a wrong reason code or a wrong index. A corrupt unicast count shows only as reason 1 changing to 2 (or the reverse) on an exact hit. A corrupt hash fold shows only for multicast addresses whose bins are selectively set. For this reason, the bench programs single bins in both hash words and moves the unicast count across a matching entry. A stuck state register shows at once as a missing or extra valid cycle.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int MAC_W      = 48;
    localparam int EN_BIT     = 16;
    localparam int MODE_PROM  = 0;
    localparam int MODE_ALLMC = 1;

    typedef enum logic [2:0] {
        RSN_DROP    = 3'd0,
        RSN_UCAST   = 3'd1,
        RSN_MCAST   = 3'd2,
        RSN_HASH    = 3'd3,
        RSN_BCAST   = 3'd4,
        RSN_PROMISC = 3'd5
    } rsn_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } st_e;

endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
    import rxaf_pkg::*;
#(
    parameter int N_ENT     = 8,
    parameter int HASH_BINS = 64,
    parameter int CFG_AW    = 5,
    parameter int CNT_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [CFG_AW-1:0]             waddr,
    input  logic [31:0]                   wdata,
    output logic [N_ENT-1:0][MAC_W-1:0]   ent_addr,
    output logic [N_ENT-1:0]              ent_en,
    output logic [HASH_BINS-1:0]          hash_q,
    output logic [1:0]                    mode_q,
    output logic [CNT_W-1:0]              ucnt_q
);
    localparam int HASH_WORDS = HASH_BINS / 32;
    localparam int A_HASH     = 2 * N_ENT;
    localparam int A_MODE     = A_HASH + HASH_WORDS;
    localparam int A_UCNT     = A_MODE + 1;

    // entry bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr <= '0;
            ent_en   <= '0;
        end else if (we) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (waddr == CFG_AW'(2 * i)) begin
                    ent_addr[i][31:0] <= wdata;
                end else if (waddr == CFG_AW'(2 * i + 1)) begin
                    ent_addr[i][MAC_W-1:32] <= wdata[MAC_W-33:0];
                    ent_en[i]               <= wdata[EN_BIT];
                end
            end
        end
    end

    // hash words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_q <= '0;
        end else if (we) begin
            for (int w = 0; w < HASH_WORDS; w++) begin
                if (waddr == CFG_AW'(A_HASH + w)) begin
                    hash_q[w*32 +: 32] <= wdata;
                end
            end
        end
    end

    // mode and unicast count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ucnt_q <= CNT_W'(1);
        end else if (we) begin
            if (waddr == CFG_AW'(A_MODE)) begin
                mode_q <= wdata[1:0];
            end
            if (waddr == CFG_AW'(A_UCNT) && wdata <= 32'(N_ENT)) begin
                ucnt_q <= wdata[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
    import rxaf_pkg::*;
#(
    parameter int HASH_W = 6
) (
    input  logic [MAC_W-1:0]  addr,
    output logic [HASH_W-1:0] bin
);
    always_comb begin
        bin = '0;
        for (int j = 0; j < MAC_W; j++) begin
            bin[j % HASH_W] = bin[j % HASH_W] ^ addr[j];
        end
    end

endmodule

// File: rtl/rxaf_cam.sv
module rxaf_cam
    import rxaf_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int IDX_W = 3
) (
    input  logic [MAC_W-1:0]              addr,
    input  logic [N_ENT-1:0][MAC_W-1:0]   ent_addr,
    input  logic [N_ENT-1:0]              ent_en,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    logic [N_ENT-1:0] eq;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
        assign eq[gi] = ent_en[gi] && (ent_addr[gi] == addr);
    end

    // lowest index wins
    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (eq[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign hit = |eq;

endmodule

// File: rtl/rxaf_top.sv
module rxaf_top
    import rxaf_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int HASH_W = 6,
    parameter int CFG_AW = 5,
    parameter int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              da_valid,
    input  logic [47:0]       da_addr,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [2:0]        dec_reason,
    output logic [IDX_W-1:0]  dec_idx
);
    localparam int HASH_BINS = 1 << HASH_W;
    localparam int CNT_W     = $clog2(N_ENT + 1);

    logic [N_ENT-1:0][MAC_W-1:0] ent_addr;
    logic [N_ENT-1:0]            ent_en;
    logic [HASH_BINS-1:0]        hash_q;
    logic [1:0]                  mode_q;
    logic [CNT_W-1:0]            ucnt_q;
    logic                        promisc_q;
    logic [HASH_W-1:0]           bin;
    logic                        cam_hit;
    logic [IDX_W-1:0]            cam_idx;
    logic [HASH_BINS-1:0]        hash_eff;
    rsn_e                        rsn_d;
    st_e                         state_q, state_d;

    rxaf_regs #(
        .N_ENT     (N_ENT),
        .HASH_BINS (HASH_BINS),
        .CFG_AW    (CFG_AW),
        .CNT_W     (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .ent_addr (ent_addr),
        .ent_en   (ent_en),
        .hash_q   (hash_q),
        .mode_q   (mode_q),
        .ucnt_q   (ucnt_q)
    );

    rxaf_hash #(.HASH_W(HASH_W)) u_hash (
        .addr (da_addr),
        .bin  (bin)
    );

    rxaf_cam #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_cam (
        .addr     (da_addr),
        .ent_addr (ent_addr),
        .ent_en   (ent_en),
        .hit      (cam_hit),
        .idx      (cam_idx)
    );

    assign promisc_q = mode_q[MODE_PROM];
    assign hash_eff  = mode_q[MODE_ALLMC] ? '1 : hash_q;

    // verdict, priority exact > broadcast > hash > promiscuous
    always_comb begin
        if (cam_hit) begin
            rsn_d = (CNT_W'(cam_idx) < ucnt_q) ? RSN_UCAST : RSN_MCAST;
        end else if (&da_addr) begin
            rsn_d = RSN_BCAST;
        end else if (da_addr[0] && hash_eff[bin]) begin
            rsn_d = RSN_HASH;
        end else if (promisc_q) begin
            rsn_d = RSN_PROMISC;
        end else begin
            rsn_d = RSN_DROP;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = da_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = da_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n || !da_valid) begin
            dec_accept <= 1'b0;
            dec_reason <= RSN_DROP;
            dec_idx    <= '0;
        end else begin
            dec_accept <= (rsn_d != RSN_DROP);
            dec_reason <= rsn_d;
            dec_idx    <= cam_hit ? cam_idx : '0;
        end
    end

    assign dec_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk #(
    parameter int N_ENT = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             da_valid,
    input logic [47:0]      da_addr,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic [2:0]       dec_reason,
    input logic [IDX_W-1:0] dec_idx,
    input logic             promisc,
    input logic [CNT_W-1:0] ucnt
);
    p_valid_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> dec_valid);

    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !dec_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && dec_reason == 3'd0 && dec_idx == '0));

    p_bcast_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && &da_addr) |=> dec_accept);

    p_promisc_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && promisc) |=> dec_accept);

    p_ucnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ucnt <= CNT_W'(N_ENT));

    p_mcast_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_reason == 3'd2) |-> (CNT_W'(dec_idx) >= $past(ucnt)));

endmodule

bind rxaf_top rxaf_chk #(
    .N_ENT (N_ENT),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .da_valid   (da_valid),
    .da_addr    (da_addr),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_reason (dec_reason),
    .dec_idx    (dec_idx),
    .promisc    (promisc_q),
    .ucnt       (ucnt_q)
);

// File: tb/test_rxaf_top.sv
`timescale 1ns/1ps
module test_rxaf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da_addr = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [2:0]  dec_reason;
    logic [2:0]  dec_idx;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [47:0] STA   = 48'h6655_4433_2210;
    localparam logic [47:0] MC3   = 48'hCDAB_125E_0001;
    localparam logic [47:0] OTHER = 48'h0102_0304_0508;

    always #4 clk = ~clk;

    rxaf_top i_rxaf_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_reason(dec_reason), .dec_idx(dec_idx)
    );

    function automatic logic [5:0] ref_bin(input logic [47:0] a);
        logic [5:0] h = '0;
        int k = 0;
        for (int by = 0; by < 6; by++) begin
            for (int bt = 0; bt < 8; bt++) begin
                h[k] = h[k] ^ a[by*8 + bt];
                k = (k == 5) ? 0 : k + 1;
            end
        end
        return h;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ent(input int i, input logic [47:0] a, input bit en);
        wr(2*i, a[31:0]);
        wr(2*i + 1, {15'd0, en, a[47:32]});
    endtask

    // one strobe, verdict sampled one cycle later
    task automatic look(input string req, input logic [47:0] a,
                        input logic [2:0] rsn, input logic [2:0] idx);
        @(negedge clk);
        da_valid = 1'b1; da_addr = a;
        @(negedge clk);
        da_valid = 1'b0;
        chk({req, " valid"}, 32'(dec_valid), 32'd1);
        chk({req, " accept"}, 32'(dec_accept), 32'(rsn != 3'd0));
        chk({req, " reason"}, 32'(dec_reason), 32'(rsn));
        chk({req, " idx"}, 32'(dec_idx), 32'(idx));
    endtask

    task automatic t_reset;
        chk("R1 valid after reset", 32'(dec_valid), 32'd0);
        look("R1 unknown unicast", STA, 3'd0, 3'd0);
        look("R1 multicast with empty hash", MC3, 3'd0, 3'd0);
    endtask

    task automatic t_exact;
        set_ent(0, STA, 1'b1);
        set_ent(3, MC3, 1'b1);
        look("R4 station entry", STA, 3'd1, 3'd0);
        look("R4 entry above count", MC3, 3'd2, 3'd3);
        look("R4 no match", OTHER, 3'd0, 3'd0);
        look("R2 reversed byte order", 48'h1022_3344_5566, 3'd0, 3'd0);
        set_ent(6, STA, 1'b1);
        look("R4 lowest index wins", STA, 3'd1, 3'd0);
        wr(1, {15'd0, 1'b0, STA[47:32]});
        look("R11 disabled entry 0 falls to 6", STA, 3'd2, 3'd6);
        set_ent(6, STA, 1'b0);
        look("R11 all copies disabled", STA, 3'd0, 3'd0);
        set_ent(0, STA, 1'b1);
    endtask

    task automatic t_ucnt;
        wr(19, 4);
        look("R3 count 4 makes entry 3 unicast", MC3, 3'd1, 3'd3);
        wr(19, 9);
        look("R3 count 9 ignored", MC3, 3'd1, 3'd3);
        wr(19, 0);
        look("R3 count 0", STA, 3'd2, 3'd0);
        wr(19, 8);
        look("R3 count 8", MC3, 3'd1, 3'd3);
        wr(19, 1);
        look("R3 count back to 1", MC3, 3'd2, 3'd3);
    endtask

    task automatic set_bin(input logic [5:0] b, input bit inv);
        logic [63:0] v = 64'd1 << b;
        if (inv) v = ~v;
        wr(16, v[31:0]);
        wr(17, v[63:32]);
    endtask

    task automatic t_hash;
        logic [47:0] list [4] = '{48'h0000_0000_0001, 48'h0000_0000_0021,
                                  48'h0100_5E7F_3A45, 48'h3333_0000_00FB};
        // bin 1 lives in low word bit 1, bin 33 in high word bit 1
        chk("R5 model bin of 01", 32'(ref_bin(list[0])), 32'd1);
        chk("R5 model bin of 21", 32'(ref_bin(list[1])), 32'd33);
        wr(16, 32'd0); wr(17, 32'h2);
        look("R5 high word bin 33", list[1], 3'd3, 3'd0);
        look("R5 bin 1 not set", list[0], 3'd0, 3'd0);
        wr(16, 32'h2); wr(17, 32'd0);
        look("R5 low word bin 1", list[0], 3'd3, 3'd0);
        look("R5 bin 33 not set", list[1], 3'd0, 3'd0);
        foreach (list[i]) begin
            set_bin(ref_bin(list[i]), 1'b0);
            look("R5 only own bin set", list[i], 3'd3, 3'd0);
            set_bin(ref_bin(list[i]), 1'b1);
            look("R5 all but own bin", list[i], 3'd0, 3'd0);
        end
        wr(16, 32'hFFFF_FFFF); wr(17, 32'hFFFF_FFFF);
        look("R6 unicast ignores hash", OTHER, 3'd0, 3'd0);
        wr(16, 32'd0); wr(17, 32'd0);
    endtask

    task automatic t_allmc;
        wr(17, 32'h2);
        wr(18, 32'h2);
        look("R7 allmulti any multicast", 48'h0000_0000_0001, 3'd3, 3'd0);
        look("R7 allmulti other multicast", 48'hA5A5_0000_7703, 3'd3, 3'd0);
        look("R7 allmulti unicast dropped", OTHER, 3'd0, 3'd0);
        wr(18, 32'h0);
        look("R7 stored words kept, bin 1 off", 48'h0000_0000_0001, 3'd0, 3'd0);
        look("R7 stored words kept, bin 33 on", 48'h0000_0000_0021, 3'd3, 3'd0);
        wr(17, 32'd0);
    endtask

    task automatic t_bcast;
        look("R8 broadcast", 48'hFFFF_FFFF_FFFF, 3'd4, 3'd0);
    endtask

    task automatic t_promisc;
        wr(18, 32'h1);
        look("R9 promisc unknown unicast", OTHER, 3'd5, 3'd0);
        look("R9 promisc keeps exact reason", STA, 3'd1, 3'd0);
        look("R9 promisc keeps bcast reason", 48'hFFFF_FFFF_FFFF, 3'd4, 3'd0);
        wr(18, 32'h0);
        look("R9 promisc cleared", OTHER, 3'd0, 3'd0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        da_valid = 1'b1; da_addr = STA;
        @(negedge clk);
        chk("R10 b2b first reason", 32'(dec_reason), 32'd1);
        chk("R10 b2b first valid", 32'(dec_valid), 32'd1);
        da_addr = OTHER;
        @(negedge clk);
        chk("R10 b2b second reason", 32'(dec_reason), 32'd0);
        chk("R10 b2b second valid", 32'(dec_valid), 32'd1);
        da_addr = MC3;
        @(negedge clk);
        chk("R10 b2b third reason", 32'(dec_reason), 32'd2);
        chk("R10 b2b third idx", 32'(dec_idx), 32'd3);
        da_valid = 1'b0; da_addr = STA;
        @(negedge clk);
        chk("R10 idle valid", 32'(dec_valid), 32'd0);
        chk("R10 idle accept", 32'(dec_accept), 32'd0);
        chk("R10 idle idx", 32'(dec_idx), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_exact();
        t_ucnt();
        t_hash();
        t_allmc();
        t_bcast();
        t_promisc();
        t_timing();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule